// File: doc/BRIEF.md
# Block-Read Issue Sequencer

This block accepts one block read at a time (start byte address plus byte count) and turns it into a series of conventional-bus memory read issues. Each issue carries a command code and a start address. The command is picked again on every issue, from the span between the current address and the last byte still owed. A plain read covers one DWORD. A line read covers several DWORDs inside one cache line. A multiple read covers a span that crosses a cache line boundary.

Returned data is counted one DWORD per accept pulse. A target disconnect ends the burst, and the block then issues again from the first byte not yet received. Received DWORDs fill a return buffer. When the buffer is full, the block ends the burst itself and raises no further issue. Issuing resumes as soon as a sector-free pulse releases a fixed group of slots.

Both the request input and the issue output use valid/ready. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the block holds no request, so a new request waits until the current one is done. Once `iss_valid` is raised, it stays high with the same command and address until `iss_ready` takes it. The downstream side may hold `iss_ready` low for as long as it needs. The data-accept, disconnect and sector-free pins are plain single-cycle events, and `done` is a plain flag. A byte count of zero must not be presented.

Top module: `blkrd_issue_seq`

## Requirements
- R1: `req_ready` is high exactly while no request is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high, after which `req_ready` stays low until the request completes.
- R2: If the unread span (current address through current address plus remaining count minus one) lies in a single DWORD, the issued command is 4'b0110.
- R3: If the span covers more than one DWORD and lies in one cache line, the command is 4'b1110. Here `cls` is a power of two in DWORDs, and a line starts at a DWORD index that is a multiple of `cls`.
- R4: If the span covers more than one DWORD and crosses a cache line boundary, the command is 4'b1100.
- R5: A `cls` of zero, or a `cls` that is not a power of two, means no line size. Any multi-DWORD span then uses 4'b1100.
- R6: A request with `req_dword` high always issues 4'b0110.
- R7: The first issue carries the request address. Each later issue carries the address of the first byte not yet received, and its command is chosen from that address and the remaining count.
- R8: In an open burst, each `dat_acc` pulse receives the bytes from the current address up to the next DWORD boundary, or the remaining count if that is smaller. A `tgt_disc` pulse in a burst that still owes bytes closes the burst and causes a new issue. `dat_acc` outside an open burst is ignored.
- R9: Each received DWORD takes one buffer slot, and the buffer holds BUF_BYTES/4 slots. When the last slot fills, the burst closes, and `iss_valid` stays low while the buffer is full.
- R10: A `sect_free` pulse frees SECTOR_BYTES/4 slots, with the count never going below zero. If the block was stalled on a full buffer, `iss_valid` rises in the next cycle.
- R11: `done` is high only in the cycle where the last owed byte's `dat_acc` is present. In the following cycle `req_ready` is high.
- R12: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_cmd` and `iss_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block read request present |
| req_ready | output | 1 | Request may be taken |
| req_addr | input | ADDR_W | Request start byte address |
| req_bytes | input | BCNT_W | Request byte count, nonzero |
| req_dword | input | 1 | Request is a single-DWORD read |
| cls | input | CLS_W | Cache line size in DWORDs |
| iss_valid | output | 1 | Read issue present |
| iss_ready | input | 1 | Read issue taken |
| iss_cmd | output | 4 | Conventional read command code |
| iss_addr | output | ADDR_W | Issue start byte address |
| dat_acc | input | 1 | One DWORD of read data accepted |
| tgt_disc | input | 1 | Target disconnected the burst |
| sect_free | input | 1 | One buffer sector released |
| done | output | 1 | Last owed byte received this cycle |

## Verification
The bench builds the block with a 16-bit address and a 64-byte buffer split into 16-byte sectors. With that buffer, a 16-slot fill is reached often in the sweep, so both the full-buffer stall and the sector-release resume are driven many times. The sweep covers every start offset in a 20-byte window, every byte count from 1 to 34, and line sizes of 2 and 4 DWORDs as well as 0 and 3. Requests that trigger a disconnect are interleaved with those that do not, so all three command codes are seen across line boundaries and again after each reissue.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [3:0] {
    CMD_MEM_RD      = 4'b0110,
    CMD_MEM_RD_LINE = 4'b1110,
    CMD_MEM_RD_MULT = 4'b1100
  } brs_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_BURST = 2'd2
  } brs_state_e;
endpackage

// File: rtl/brs_cmd_sel.sv
module brs_cmd_sel
  import brs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BCNT_W = 12,
  parameter int CLS_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BCNT_W-1:0] remain,
  input  logic [CLS_W-1:0]  cls,
  input  logic              dword_only,
  output brs_cmd_e          cmd
);
  localparam int DW_W = ADDR_W - 2;

  logic [ADDR_W-1:0] end_addr;
  logic [DW_W-1:0]   first_dw, end_dw, low_mask;
  logic              line_ok, one_dw, same_line;

  always_comb begin
    end_addr  = addr + {{(ADDR_W-BCNT_W){1'b0}}, remain} - {{(ADDR_W-1){1'b0}}, 1'b1};
    first_dw  = addr[ADDR_W-1:2];
    end_dw    = end_addr[ADDR_W-1:2];
    one_dw    = (first_dw == end_dw);
    line_ok   = (cls != '0) && ((cls & (cls - {{(CLS_W-1){1'b0}}, 1'b1})) == '0);
    low_mask  = {{(DW_W-CLS_W){1'b0}}, cls - {{(CLS_W-1){1'b0}}, 1'b1}};
    same_line = (((first_dw ^ end_dw) & ~low_mask) == '0);
    if (dword_only || one_dw)       cmd = CMD_MEM_RD;
    else if (line_ok && same_line)  cmd = CMD_MEM_RD_LINE;
    else                            cmd = CMD_MEM_RD_MULT;
  end
endmodule

// File: rtl/brs_step.sv
module brs_step #(
  parameter int ADDR_W = 32,
  parameter int BCNT_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BCNT_W-1:0] remain,
  output logic [ADDR_W-1:0] next_addr,
  output logic [BCNT_W-1:0] next_remain,
  output logic              last
);
  logic [2:0]        room;
  logic [BCNT_W-1:0] room_w;

  always_comb begin
    room        = 3'd4 - {1'b0, addr[1:0]};
    room_w      = {{(BCNT_W-3){1'b0}}, room};
    last        = (remain <= room_w);
    next_addr   = {addr[ADDR_W-1:2] + {{(ADDR_W-3){1'b0}}, 1'b1}, 2'b00};
    next_remain = last ? '0 : (remain - room_w);
  end
endmodule

// File: rtl/brs_occ.sv
module brs_occ #(
  parameter int CAP_DW  = 128,
  parameter int SECT_DW = 32,
  parameter int OCC_W   = $clog2(CAP_DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             release_sect,
  output logic [OCC_W-1:0] occ,
  output logic             full,
  output logic             one_left
);
  localparam logic [OCC_W-1:0] CAP  = OCC_W'(CAP_DW);
  localparam logic [OCC_W:0]   SECT = (OCC_W+1)'(SECT_DW);

  logic [OCC_W:0] sum;
  logic [OCC_W:0] nxt;

  always_comb begin
    sum = {1'b0, occ} + {{OCC_W{1'b0}}, inc};
    if (release_sect) nxt = (sum >= SECT) ? (sum - SECT) : '0;
    else              nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= nxt[OCC_W-1:0];
  end

  assign full     = (occ == CAP);
  assign one_left = (occ == CAP - {{(OCC_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/blkrd_issue_seq.sv
module blkrd_issue_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int BCNT_W       = 12,
  parameter int CLS_W        = 8,
  parameter int BUF_BYTES    = 512,
  parameter int SECTOR_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BCNT_W-1:0] req_bytes,
  input  logic              req_dword,
  input  logic [CLS_W-1:0]  cls,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [3:0]        iss_cmd,
  output logic [ADDR_W-1:0] iss_addr,
  input  logic              dat_acc,
  input  logic              tgt_disc,
  input  logic              sect_free,
  output logic              done
);
  localparam int CAP_DW  = BUF_BYTES / 4;
  localparam int SECT_DW = SECTOR_BYTES / 4;
  localparam int OCC_W   = $clog2(CAP_DW + 1);

  brs_state_e        state;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [BCNT_W-1:0] remain, nxt_remain;
  logic              dword_req;
  logic              last, beat, full, one_left;
  logic [OCC_W-1:0]  occ;
  brs_cmd_e          cmd;

  brs_cmd_sel #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W), .CLS_W(CLS_W)) u_cmd (
    .addr(cur_addr), .remain(remain), .cls(cls), .dword_only(dword_req), .cmd(cmd)
  );

  brs_step #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) u_step (
    .addr(cur_addr), .remain(remain), .next_addr(nxt_addr),
    .next_remain(nxt_remain), .last(last)
  );

  brs_occ #(.CAP_DW(CAP_DW), .SECT_DW(SECT_DW), .OCC_W(OCC_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .inc(beat), .release_sect(sect_free),
    .occ(occ), .full(full), .one_left(one_left)
  );

  assign req_ready = (state == ST_IDLE);
  assign iss_valid = (state == ST_ISSUE) && !full;
  assign iss_cmd   = cmd;
  assign iss_addr  = cur_addr;
  assign beat      = (state == ST_BURST) && dat_acc;
  assign done      = beat && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      remain    <= '0;
      dword_req <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr  <= req_addr;
          remain    <= req_bytes;
          dword_req <= req_dword;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: if (iss_valid && iss_ready) state <= ST_BURST;
        ST_BURST: begin
          if (beat) begin
            cur_addr <= nxt_addr;
            remain   <= nxt_remain;
            if (last)                               state <= ST_IDLE;
            else if (tgt_disc || (one_left && !sect_free)) state <= ST_ISSUE;
          end else if (tgt_disc) begin
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
  parameter int ADDR_W = 32,
  parameter int OCC_W  = 8,
  parameter int CAP_DW = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [3:0]        iss_cmd,
  input logic [ADDR_W-1:0] iss_addr,
  input logic              done,
  input logic [OCC_W-1:0]  occ
);
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !iss_valid); // R1
  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_cmd == 4'b0110 || iss_cmd == 4'b1110 || iss_cmd == 4'b1100)); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(CAP_DW)) |-> !iss_valid); // R9
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(CAP_DW)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R11
  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_cmd) && $stable(iss_addr))); // R12
endmodule

bind blkrd_issue_seq brs_chk #(.ADDR_W(ADDR_W), .OCC_W(OCC_W), .CAP_DW(CAP_DW)) u_brs_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_cmd(iss_cmd), .iss_addr(iss_addr), .done(done), .occ(occ)
);

// File: tb/blkrd_issue_seq_bench.sv
module blkrd_issue_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int BW   = 12;
  localparam int CW   = 8;
  localparam int BUFB = 64;
  localparam int SECB = 16;
  localparam int CAP  = BUFB / 4;
  localparam int SECT = SECB / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_dword = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_bytes = '0;
  logic [CW-1:0] cls = '0;
  logic          iss_ready = 1'b0, dat_acc = 1'b0, tgt_disc = 1'b0, sect_free = 1'b0;
  logic          req_ready, iss_valid, done;
  logic [3:0]    iss_cmd;
  logic [AW-1:0] iss_addr;

  int checks = 0, fails = 0, bocc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkrd_issue_seq #(.ADDR_W(AW), .BCNT_W(BW), .CLS_W(CW), .BUF_BYTES(BUFB),
                    .SECTOR_BYTES(SECB)) u_blkrd_issue_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_dword(req_dword), .cls(cls),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cmd(iss_cmd), .iss_addr(iss_addr),
    .dat_acc(dat_acc), .tgt_disc(tgt_disc), .sect_free(sect_free), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cmd(input int a, input int r, input int c, input bit dw);
    int f, l;
    bit p2;
    f = a / 4;
    l = (a + r - 1) / 4;
    p2 = 0;
    for (int k = 0; k < CW; k++) if (c == (1 << k)) p2 = 1;
    if (dw || f == l) return 4'b0110;
    if (p2 && (f / c) == (l / c)) return 4'b1110;
    return 4'b1100;
  endfunction

  function automatic string cmd_tag(input int a, input int r, input int c, input bit dw);
    int f, l;
    f = a / 4;
    l = (a + r - 1) / 4;
    if (dw) return "R6";
    if (f == l) return "R2";
    if (c == 0 || c == 3) return "R5";
    return (exp_cmd(a, r, c, dw) == 4'b1110) ? "R3" : "R4";
  endfunction

  task automatic run_req(input int a0, input int n, input int c, input bit dw,
                         input int disc_n, input bit hold);
    int a, rem, cnt, take;
    bit lst, stop, first;
    a = a0; rem = n; first = 1;
    @(negedge clk);
    cls = CW'(c); req_addr = AW'(a0); req_bytes = BW'(n); req_dword = dw; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R1 ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk(req_ready == 1'b0, "R1 ready busy", req_ready, 0);
    while (rem > 0) begin
      if (bocc >= CAP) begin
        chk(iss_valid == 1'b0, "R9 stall full", iss_valid, 0);
        sect_free = 1'b1;
        @(negedge clk);
        sect_free = 1'b0;
        bocc = bocc - SECT;
        #1;
      end
      chk(iss_valid == 1'b1, first ? "R10 or R1 issue" : "R10 resume", iss_valid, 1);
      chk(iss_addr == AW'(a), first ? "R7 first addr" : "R7 reissue addr", iss_addr, a);
      chk(iss_cmd == 4'(exp_cmd(a, rem, c, dw)), cmd_tag(a, rem, c, dw), iss_cmd,
          exp_cmd(a, rem, c, dw));
      if (hold) begin
        dat_acc = 1'b1;
        @(negedge clk);
        dat_acc = 1'b0;
        #1;
        chk(iss_valid == 1'b1 && iss_addr == AW'(a), "R12 hold / R8 ignore", iss_addr, a);
        chk(iss_cmd == 4'(exp_cmd(a, rem, c, dw)), "R12 cmd stable", iss_cmd,
            exp_cmd(a, rem, c, dw));
      end
      iss_ready = 1'b1;
      @(negedge clk);
      iss_ready = 1'b0;
      first = 0;
      cnt = 0; stop = 0;
      while (!stop) begin
        take = 4 - (a % 4);
        if (take > rem) take = rem;
        lst = (take == rem);
        dat_acc = 1'b1;
        tgt_disc = (disc_n != 0 && cnt + 1 == disc_n && !lst);
        #1 chk(done == lst, lst ? "R11 done last" : "R11 no early done", done, lst);
        @(negedge clk);
        dat_acc = 1'b0; tgt_disc = 1'b0;
        cnt++; bocc++;
        rem = rem - take;
        a = a + take;
        if (lst || bocc >= CAP || (disc_n != 0 && cnt == disc_n)) stop = 1;
      end
    end
    #1 chk(req_ready == 1'b1 && done == 1'b0, "R11 back to idle", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cls_set[4];
    cls_set[0] = 4; cls_set[1] = 2; cls_set[2] = 0; cls_set[3] = 3;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(iss_valid == 1'b0, "R1 reset no issue", iss_valid, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int off = 0; off < 20; off++)
        for (int n = 1; n <= 34; n++)
          run_req(256 + off, n, cls_set[k], 1'b0, ((off + n) % 2 == 1) ? 2 : 0,
                  ((off + n) % 5 == 0));
    for (int off = 0; off < 4; off++)
      for (int n = 1; n <= 4 - off; n++)
        run_req(512 + off, n, 4, 1'b1, 0, 1'b0);
    // R10: sector release saturates at zero when fewer slots are held
    while (bocc > 0) begin
      @(negedge clk); sect_free = 1'b1;
      @(negedge clk); sect_free = 1'b0;
      bocc = (bocc > SECT) ? bocc - SECT : 0;
    end
    @(negedge clk); sect_free = 1'b1;
    @(negedge clk); sect_free = 1'b0;
    run_req(1024, 64, 0, 1'b0, 0, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule